// File: doc/BRIEF.md
# Partitioned Comparison Result Combiner

This block sits behind a lane-split comparator whose lanes can be joined into wider partitions at runtime. Each lane hands over two bits: one that says its slice of the operands compared equal, and one that says its slice compared greater. A boundary vector says where one partition ends and the next begins. The block merges the per-lane bits of each partition into a single result, which is placed on the output bit of the partition's first lane. All other output bits are held at zero.

A single select input picks the kind of result. In greater mode the merge runs as a ripple: a lane decides the result unless it compared equal, and only then does the next lane decide. Lower lane indices count as more significant. In equality mode the same chain is used with every greater bit forced to zero and the chain's end value set to one, so each partition's result becomes the AND of its equal bits. The block is purely combinational and has no clock or reset.

Top module: `prc_combiner`

## Requirements
- R1: With mode_sel_i = 0 (greater mode) and both boundary bits at 1 (three separate lanes), every output bit equals its own lane's greater bit.
- R2: Boundary bit k (bnd_i[k]) set to 1 puts a boundary between lane k and lane k+1; 0 joins them. In greater mode with bnd_i = 2'b10 (lanes 0 and 1 joined), res_o[0] = gt0 | (eq0 & gt1), res_o[1] = 0 and res_o[2] = gt2.
- R3: In greater mode with bnd_i = 2'b01 (lanes 1 and 2 joined), res_o[0] = gt0, res_o[1] = gt1 | (eq1 & gt2) and res_o[2] = 0.
- R4: In greater mode with bnd_i = 2'b00 (one partition), res_o[0] = gt0 | (eq0 & (gt1 | (eq1 & gt2))) and res_o[2:1] = 0; lane 0 is the most significant.
- R5: With mode_sel_i = 1 (equality mode) and bnd_i = 2'b11, res_o equals eq_i.
- R6: In equality mode with bnd_i = 2'b00, res_o[0] = eq0 & eq1 & eq2 and res_o[2:1] = 0.
- R7: In equality mode, bnd_i = 2'b10 gives res_o = {eq2, 0, eq0 & eq1}, and bnd_i = 2'b01 gives res_o = {0, eq1 & eq2, eq0}.
- R8: In equality mode the greater inputs have no effect on res_o.
- R9: In both modes, any output bit whose lane does not start a partition (lane k > 0 with bnd_i[k-1] = 0) is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| eq_i | input | LANES (3) | Per-lane equal flags, bit k for lane k |
| gt_i | input | LANES (3) | Per-lane greater flags, bit k for lane k |
| bnd_i | input | LANES-1 (2) | Boundary flags, bit k between lanes k and k+1 |
| mode_sel_i | input | 1 | 0 selects greater merge, 1 selects equality merge |
| res_o | output | LANES (3) | Merged result on each partition's first lane |

## Verification
The bench builds the block with its default of three lanes and therefore two boundary bits, which makes the full input space only 512 combinations of equal, greater, boundary and mode bits. Every combination is applied, so all four partition layouts are seen in both modes with every pattern of lane flags, including equality mode with nonzero greater bits. Expected results are computed in the bench from the per-layout formulas rather than from a chain.

// File: rtl/prc_pkg.sv
package prc_pkg;

    typedef enum logic {
        MERGE_GT = 1'b0,
        MERGE_EQ = 1'b1
    } merge_mode_e;

    // One step of the merge chain: this lane decides unless it compared
    // equal, in which case the less significant remainder decides.
    function automatic logic lane_step(input logic gt_b,
                                       input logic eq_b,
                                       input logic rest_b);
        return gt_b | (eq_b & rest_b);
    endfunction

endpackage

// File: rtl/prc_chain.sv
module prc_chain #(
    parameter int LANES = 3,
    localparam int BW = LANES - 1
) (
    input  logic [LANES-1:0] eq_i,
    input  logic [LANES-1:0] gt_i,
    input  logic [BW-1:0]    bnd_i,
    input  prc_pkg::merge_mode_e mode_i,
    output logic [LANES-1:0] chain_o
);
    import prc_pkg::*;

    logic             end_val;
    logic [LANES-1:0] gt_eff;

    always_comb begin
        end_val = (mode_i == MERGE_EQ);
        gt_eff  = end_val ? '0 : gt_i;
    end

    // Walk from the least significant lane upward so no bit depends on a
    // later assignment in the same vector.
    always_comb begin
        logic acc;
        chain_o = '0;
        acc     = end_val;
        for (int k = LANES - 1; k >= 0; k--) begin
            if (k < LANES - 1) begin
                if (bnd_i[k]) acc = end_val;
            end
            acc        = lane_step(gt_eff[k], eq_i[k], acc);
            chain_o[k] = acc;
        end
    end

    // In equality mode a chain bit can only be set where the lane is equal.
    always_comb begin
        for (int k = 0; k < LANES; k++) begin
            if (mode_i == MERGE_EQ && chain_o[k])
                p_eq_needs_equal_r8: assert (eq_i[k]);
        end
    end

endmodule

// File: rtl/prc_start_mask.sv
module prc_start_mask #(
    parameter int LANES = 3,
    localparam int BW = LANES - 1
) (
    input  logic [BW-1:0]    bnd_i,
    input  logic [LANES-1:0] chain_i,
    output logic [LANES-1:0] res_o
);
    logic [LANES-1:0] head;

    generate
        for (genvar k = 0; k < LANES; k++) begin : g_head
            if (k == 0) begin : g_first
                assign head[k] = 1'b1;
            end else begin : g_rest
                assign head[k] = bnd_i[k-1];
            end
        end
    endgenerate

    assign res_o = chain_i & head;

endmodule

// File: rtl/prc_combiner.sv
module prc_combiner #(
    parameter int LANES = 3,
    localparam int BW = LANES - 1
) (
    input  logic [LANES-1:0] eq_i,
    input  logic [LANES-1:0] gt_i,
    input  logic [BW-1:0]    bnd_i,
    input  logic             mode_sel_i,
    output logic [LANES-1:0] res_o
);
    import prc_pkg::*;

    merge_mode_e      mode_d;
    logic [LANES-1:0] chain_d;

    assign mode_d = merge_mode_e'(mode_sel_i);

    prc_chain #(.LANES(LANES)) u_chain (
        .eq_i    (eq_i),
        .gt_i    (gt_i),
        .bnd_i   (bnd_i),
        .mode_i  (mode_d),
        .chain_o (chain_d)
    );

    prc_start_mask #(.LANES(LANES)) u_mask (
        .bnd_i   (bnd_i),
        .chain_i (chain_d),
        .res_o   (res_o)
    );

    always_comb begin
        if (!mode_sel_i && (&bnd_i))
            p_open_gt_passthru_r1: assert (res_o == gt_i);
        if (mode_sel_i && (&bnd_i))
            p_open_eq_passthru_r5: assert (res_o == eq_i);
        if (mode_sel_i && (bnd_i == '0))
            p_joined_eq_and_r6: assert (res_o[0] == (&eq_i));
        for (int k = 1; k < LANES; k++) begin
            if (!bnd_i[k-1])
                p_inner_lane_zero_r9: assert (!res_o[k]);
        end
    end

endmodule

// File: tb/prc_combiner_tb.sv
module prc_combiner_tb;

    logic       clk = 1'b0;
    logic [2:0] eq_i = '0;
    logic [2:0] gt_i = '0;
    logic [1:0] bnd_i = '0;
    logic       mode_sel_i = 1'b0;
    logic [2:0] res_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    prc_combiner #(.LANES(3)) u_dut (
        .eq_i       (eq_i),
        .gt_i       (gt_i),
        .bnd_i      (bnd_i),
        .mode_sel_i (mode_sel_i),
        .res_o      (res_o)
    );

    task automatic check(input string req, input logic [2:0] act,
                         input logic [2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s eq=%b gt=%b bnd=%b mode=%b actual=%b expected=%b",
                     req, eq_i, gt_i, bnd_i, mode_sel_i, act, exp);
        end
    endtask

    function automatic logic [2:0] model(input logic [2:0] e, input logic [2:0] g,
                                         input logic [1:0] b, input logic m);
        logic [2:0] r;
        if (!m) begin
            case (b)
                2'b11: r = g;
                2'b10: r = {g[2], 1'b0, g[0] | (e[0] & g[1])};
                2'b01: r = {1'b0, g[1] | (e[1] & g[2]), g[0]};
                default: r = {2'b00, g[0] | (e[0] & (g[1] | (e[1] & g[2])))};
            endcase
        end else begin
            case (b)
                2'b11: r = e;
                2'b10: r = {e[2], 1'b0, e[0] & e[1]};
                2'b01: r = {1'b0, e[1] & e[2], e[0]};
                default: r = {2'b00, e[0] & e[1] & e[2]};
            endcase
        end
        return r;
    endfunction

    function automatic string tag_of(input logic [1:0] b, input logic m);
        if (!m) begin
            case (b)
                2'b11: return "R1";
                2'b10: return "R2";
                2'b01: return "R3";
                default: return "R4";
            endcase
        end
        case (b)
            2'b11: return "R5";
            2'b00: return "R6";
            default: return "R7";
        endcase
    endfunction

    initial begin
        // Idle state with all inputs low, gt mode, one partition.
        @(negedge clk);
        check("R4", res_o, 3'b000);
        for (int v = 0; v < 512; v++) begin
            logic [2:0] e_ref;
            logic [1:0] b_ref;
            @(posedge clk);
            eq_i       = v[2:0];
            gt_i       = v[5:3];
            bnd_i      = v[7:6];
            mode_sel_i = v[8];
            @(negedge clk);
            check(tag_of(bnd_i, mode_sel_i), res_o,
                  model(eq_i, gt_i, bnd_i, mode_sel_i));
            // R9: lanes that do not open a partition stay low.
            b_ref = bnd_i;
            check("R9", res_o & {~b_ref[1], ~b_ref[0], 1'b0}, 3'b000);
            // R8: in equality mode the result matches the greater-free case.
            if (mode_sel_i && gt_i != 3'b000) begin
                e_ref = res_o;
                @(posedge clk);
                gt_i = 3'b000;
                @(negedge clk);
                check("R8", res_o, e_ref);
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_checks, n_fails);
        $finish;
    end

endmodule